// File: doc/BRIEF.md
# Cluster Cross-Core Semaphore Unit

This unit holds the counting semaphores a cluster uses to pass events between one matrix core and two vector subcores. Each of the three cores has its own sequencer and issues its own signal and wait requests. The semaphore state has two directions. Matrix-to-vector counters are waited on by a subcore. Vector-to-matrix counters are waited on by the matrix core. Each direction has one bank of counters per subcore, indexed by a short semaphore ID.

A static configuration input picks one of two behaviours, and the unit latches it while reset is held. In the shared mode, a single matrix signal raises the addressed counter in both subcores. A single matrix wait completes only when both subcores have signalled, and it takes one count from each. A wait that cannot complete stalls every pipe of the waiting core. In the directed mode, the matrix core uses a wider ID whose top bit selects the subcore, so reaching both subcores takes two separate operations. A pending wait then stalls only the pipe it names.

A wait is held valid by its core. It completes combinationally in any cycle in which its counter is nonzero, and the count falls by one at the next clock edge. Counters saturate at their maximum value, and saturation raises a sticky flag.

Top module: `xcore_sema`

## Requirements
- R1: While reset is held and in the first cycle after it, every counter reads zero: no wait completes, no stall is raised without a pending wait, and the saturation flag is low.
- R2: In shared mode (`cfg_p2p`=0), one matrix signal raises the counter for ID `m_sig_id[3:0]` in both subcores, and bit 4 of the ID is ignored.
- R3: In shared mode, a matrix wait on ID n completes only when the vector-to-matrix counters for n are nonzero in both subcores, and its completion takes exactly one count from each.
- R4: In shared mode, a pending wait that cannot complete drives every bit of the waiter's stall vector high.
- R5: In directed mode (`cfg_p2p`=1), a matrix signal with `m_sig_id` 0–15 raises only subcore 0's counter `id[3:0]`, and an ID of 16–31 raises only subcore 1's counter.
- R6: In directed mode, a matrix wait with ID 0–15 completes on subcore 0's counter alone, and an ID of 16–31 completes on subcore 1's counter alone.
- R7: In directed mode, a pending wait that cannot complete raises only the stall bit whose index equals its pipe field (0, 1 or 2). All other stall bits stay low.
- R8: A wait completes in the same cycle it is presented if its counter is nonzero, and each completion lowers that counter by exactly one.
- R9: A signal to a counter at 15 leaves it at 15 and sets `sat_flag`, which stays high until reset.
- R10: `cfg_p2p` is sampled only while reset is held, and later changes to it have no effect on behaviour.
- R11: A signal and a completing wait on the same counter in the same cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is latched while low |
| cfg_p2p | input | 1 | Mode select: 0 shared, 1 directed |
| m_sig_valid | input | 1 | Matrix core signal request |
| m_sig_id | input | 5 | Matrix signal ID; bit 4 picks the subcore in directed mode |
| m_wait_valid | input | 1 | Matrix core wait request, held until done |
| m_wait_id | input | 5 | Matrix wait ID; bit 4 picks the subcore in directed mode |
| m_wait_pipe | input | 2 | Pipe named by the matrix wait |
| m_wait_done | output | 1 | Matrix wait completes this cycle |
| m_stall | output | 3 | Matrix core per-pipe stall |
| v_sig_valid | input | 2 | Per-subcore signal request |
| v_sig_id | input | 2x4 | Per-subcore signal ID |
| v_wait_valid | input | 2 | Per-subcore wait request, held until done |
| v_wait_id | input | 2x4 | Per-subcore wait ID |
| v_wait_pipe | input | 2x2 | Pipe named by each subcore wait |
| v_wait_done | output | 2 | Per-subcore wait completes this cycle |
| v_stall | output | 2x3 | Per-subcore per-pipe stall |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The assertions assume that a pipe field always names an existing pipe (0 to 2). They also assume that a decrement reaches a counter only through a completing wait, and that completion is gated on a nonzero count. The underflow property therefore depends on the inputs never bypassing that gating. The bench drives pipe fields only with values 0–2 and changes inputs only on falling edges. It presents each wait for one cycle and then drops it. It reads counter contents solely by issuing waits and observing `m_wait_done` and `v_wait_done`.

// File: rtl/xcore_sema_pkg.sv
package xcore_sema_pkg;
   typedef enum logic {
      MODE_SHARED   = 1'b0,
      MODE_DIRECTED = 1'b1
   } sema_mode_e;

   localparam int NUM_SUB = 2;
endpackage

// File: rtl/xcore_sema_ctr.sv
module xcore_sema_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             sat_evt
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   assign sat_evt = inc && !dec && (cnt_q == CMAX);
   assign cnt     = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc && !dec && (cnt_q != CMAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (dec && !inc) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R8: a completed wait never finds an empty counter
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt_q != '0));

   // R8: a lone completion lowers the count by exactly one
   assert_dec_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

   // R9: a full counter stays full under a lone signal
   assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && cnt_q == CMAX) |=> (cnt_q == CMAX));

   // R11: signal and completion together cancel
   assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(cnt_q));
endmodule

// File: rtl/xcore_sema_bank.sv
module xcore_sema_bank #(
   parameter int NUM_IDS = 16,
   parameter int CNT_W   = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             inc_v,
   input  logic [$clog2(NUM_IDS)-1:0]       inc_id,
   input  logic                             dec_v,
   input  logic [$clog2(NUM_IDS)-1:0]       dec_id,
   output logic [NUM_IDS-1:0][CNT_W-1:0]    cnt_o,
   output logic                             sat_o
);
   localparam int IDW = $clog2(NUM_IDS);

   logic [NUM_IDS-1:0] sat_vec;

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_ctr
      logic hit_inc;
      logic hit_dec;
      assign hit_inc = inc_v && (inc_id == IDW'(i));
      assign hit_dec = dec_v && (dec_id == IDW'(i));
      xcore_sema_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (hit_inc),
         .dec     (hit_dec),
         .cnt     (cnt_o[i]),
         .sat_evt (sat_vec[i])
      );
   end

   assign sat_o = |sat_vec;
endmodule

// File: rtl/xcore_sema_stall.sv
module xcore_sema_stall #(
   parameter int NUM_PIPES = 3
) (
   input  logic                          directed,
   input  logic                          pending,
   input  logic [$clog2(NUM_PIPES)-1:0]  pipe,
   output logic [NUM_PIPES-1:0]          stall
);
   localparam int PW = $clog2(NUM_PIPES);

   for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      assign stall[p] = pending && (!directed || (pipe == PW'(p)));
   end

   // R4: shared-mode pending wait halts the whole core
   assert_all_stall_R4: assert final (!(pending && !directed) || (&stall));

   // R7: directed-mode stall touches at most one pipe
   assert_one_stall_R7: assert final (!directed || $onehot0(stall));
endmodule

// File: rtl/xcore_sema.sv
module xcore_sema
   import xcore_sema_pkg::*;
#(
   parameter int NUM_IDS   = 16,
   parameter int CNT_W     = 4,
   parameter int NUM_PIPES = 3
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    cfg_p2p,
   input  logic                                    m_sig_valid,
   input  logic [$clog2(NUM_IDS):0]                m_sig_id,
   input  logic                                    m_wait_valid,
   input  logic [$clog2(NUM_IDS):0]                m_wait_id,
   input  logic [$clog2(NUM_PIPES)-1:0]            m_wait_pipe,
   output logic                                    m_wait_done,
   output logic [NUM_PIPES-1:0]                    m_stall,
   input  logic [1:0]                              v_sig_valid,
   input  logic [1:0][$clog2(NUM_IDS)-1:0]         v_sig_id,
   input  logic [1:0]                              v_wait_valid,
   input  logic [1:0][$clog2(NUM_IDS)-1:0]         v_wait_id,
   input  logic [1:0][$clog2(NUM_PIPES)-1:0]       v_wait_pipe,
   output logic [1:0]                              v_wait_done,
   output logic [1:0][NUM_PIPES-1:0]               v_stall,
   output logic                                    sat_flag
);
   localparam int IDW = $clog2(NUM_IDS);

   if (NUM_IDS < 2 || (1 << IDW) != NUM_IDS) begin : g_bad_ids
      $error("xcore_sema: NUM_IDS must be a power of two of at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("xcore_sema: CNT_W must be positive");
   end
   if (NUM_PIPES < 2) begin : g_bad_pipes
      $error("xcore_sema: NUM_PIPES must be at least 2");
   end

   sema_mode_e mode_q;
   logic       directed;
   logic       sat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= sema_mode_e'(cfg_p2p);
   end
   assign directed = (mode_q == MODE_DIRECTED);

   logic [NUM_SUB-1:0][NUM_IDS-1:0][CNT_W-1:0] m2v_cnt;
   logic [NUM_SUB-1:0][NUM_IDS-1:0][CNT_W-1:0] v2m_cnt;
   logic [NUM_SUB-1:0]                         m2v_sat;
   logic [NUM_SUB-1:0]                         v2m_sat;
   logic [NUM_SUB-1:0]                         m_avail;
   logic [IDW-1:0]                             m_slot;
   logic                                       m_sub;

   assign m_slot = m_wait_id[IDW-1:0];
   assign m_sub  = m_wait_id[IDW];

   for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
      logic m2v_inc;
      logic v2m_dec;
      logic v_pend;

      assign m2v_inc     = m_sig_valid && (!directed || (m_sig_id[IDW] == 1'(s)));
      assign v_wait_done[s] = v_wait_valid[s] && (m2v_cnt[s][v_wait_id[s]] != '0);
      assign m_avail[s]  = (v2m_cnt[s][m_slot] != '0);
      assign v2m_dec     = m_wait_done && (!directed || (m_sub == 1'(s)));
      assign v_pend      = v_wait_valid[s] && !v_wait_done[s];

      xcore_sema_bank #(.NUM_IDS(NUM_IDS), .CNT_W(CNT_W)) u_m2v (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc_v  (m2v_inc),
         .inc_id (m_sig_id[IDW-1:0]),
         .dec_v  (v_wait_done[s]),
         .dec_id (v_wait_id[s]),
         .cnt_o  (m2v_cnt[s]),
         .sat_o  (m2v_sat[s])
      );

      xcore_sema_bank #(.NUM_IDS(NUM_IDS), .CNT_W(CNT_W)) u_v2m (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc_v  (v_sig_valid[s]),
         .inc_id (v_sig_id[s]),
         .dec_v  (v2m_dec),
         .dec_id (m_slot),
         .cnt_o  (v2m_cnt[s]),
         .sat_o  (v2m_sat[s])
      );

      xcore_sema_stall #(.NUM_PIPES(NUM_PIPES)) u_vstall (
         .directed (directed),
         .pending  (v_pend),
         .pipe     (v_wait_pipe[s]),
         .stall    (v_stall[s])
      );
   end

   assign m_wait_done = m_wait_valid && (directed ? m_avail[m_sub] : (&m_avail));

   xcore_sema_stall #(.NUM_PIPES(NUM_PIPES)) u_mstall (
      .directed (directed),
      .pending  (m_wait_valid && !m_wait_done),
      .pipe     (m_wait_pipe),
      .stall    (m_stall)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) sat_q <= 1'b0;
      else if ((|m2v_sat) || (|v2m_sat)) sat_q <= 1'b1;
   end
   assign sat_flag = sat_q;

   // R10: latched mode never moves outside reset
   assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(mode_q));

   // R9: saturation indicator is sticky
   assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sat_q |=> sat_q);

   // R3: a shared-mode matrix completion drains one count from each subcore
   assert_reduce_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wait_done && !directed && !(|v_sig_valid)) |=>
         (v2m_cnt[0][$past(m_slot)] == CNT_W'($past(v2m_cnt[0][m_slot]) - 1'b1)) &&
         (v2m_cnt[1][$past(m_slot)] == CNT_W'($past(v2m_cnt[1][m_slot]) - 1'b1)));

   // R8: a completing wait raises no stall
   assert_done_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_wait_done |-> (m_stall == '0));
endmodule

// File: tb/xcore_sema_test.sv
module xcore_sema_test;
   logic            clk = 1'b0;
   logic            rst_n;
   logic            cfg_p2p;
   logic            m_sig_valid;
   logic [4:0]      m_sig_id;
   logic            m_wait_valid;
   logic [4:0]      m_wait_id;
   logic [1:0]      m_wait_pipe;
   logic            m_wait_done;
   logic [2:0]      m_stall;
   logic [1:0]      v_sig_valid;
   logic [1:0][3:0] v_sig_id;
   logic [1:0]      v_wait_valid;
   logic [1:0][3:0] v_wait_id;
   logic [1:0][1:0] v_wait_pipe;
   logic [1:0]      v_wait_done;
   logic [1:0][2:0] v_stall;
   logic            sat_flag;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   xcore_sema uut (
      .clk(clk), .rst_n(rst_n), .cfg_p2p(cfg_p2p),
      .m_sig_valid(m_sig_valid), .m_sig_id(m_sig_id),
      .m_wait_valid(m_wait_valid), .m_wait_id(m_wait_id), .m_wait_pipe(m_wait_pipe),
      .m_wait_done(m_wait_done), .m_stall(m_stall),
      .v_sig_valid(v_sig_valid), .v_sig_id(v_sig_id),
      .v_wait_valid(v_wait_valid), .v_wait_id(v_wait_id), .v_wait_pipe(v_wait_pipe),
      .v_wait_done(v_wait_done), .v_stall(v_stall), .sat_flag(sat_flag)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      m_sig_valid = 0; m_sig_id = '0; m_wait_valid = 0; m_wait_id = '0; m_wait_pipe = '0;
      v_sig_valid = '0; v_sig_id = '0; v_wait_valid = '0; v_wait_id = '0; v_wait_pipe = '0;
   endtask

   task automatic do_reset(logic p2p);
      @(negedge clk);
      idle_inputs();
      rst_n = 0; cfg_p2p = p2p;
      repeat (3) step();
      rst_n = 1;
   endtask

   task automatic m_signal(int id);
      m_sig_valid = 1; m_sig_id = 5'(id);
      step();
      m_sig_valid = 0;
   endtask

   task automatic v_signal(int s, int id);
      v_sig_valid[s] = 1; v_sig_id[s] = 4'(id);
      step();
      v_sig_valid = '0;
   endtask

   // present a subcore wait for one cycle, check completion and stall
   task automatic v_try(string req, int s, int id, int pipe, int exp_done, int exp_stall);
      v_wait_valid[s] = 1; v_wait_id[s] = 4'(id); v_wait_pipe[s] = 2'(pipe);
      #1;
      check(req, int'(v_wait_done[s]), exp_done);
      if (exp_stall >= 0) check(req, int'(v_stall[s]), exp_stall);
      step();
      v_wait_valid = '0;
   endtask

   task automatic m_try(string req, int id, int pipe, int exp_done, int exp_stall);
      m_wait_valid = 1; m_wait_id = 5'(id); m_wait_pipe = 2'(pipe);
      #1;
      check(req, int'(m_wait_done), exp_done);
      if (exp_stall >= 0) check(req, int'(m_stall), exp_stall);
      step();
      m_wait_valid = 0;
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      #1;
      check("R1 no matrix done", int'(m_wait_done), 0);
      check("R1 no stall", int'(m_stall), 0);
      check("R1 sat low", int'(sat_flag), 0);
      v_try("R1 empty counter", 0, 3, 0, 0, 7);
      m_try("R1 empty counter", 3, 0, 0, 7);
   endtask

   task automatic t_shared_signal();
      do_reset(1'b0);
      m_signal(16 + 5);                       // bit 4 ignored in shared mode
      v_try("R2 subcore0 gets signal", 0, 5, 0, 1, 0);
      v_try("R2 subcore1 gets signal", 1, 5, 0, 1, 0);
      v_try("R8 count consumed", 0, 5, 0, 0, -1);
      v_try("R8 count consumed", 1, 5, 0, 0, -1);
   endtask

   task automatic t_shared_reduce();
      do_reset(1'b0);
      v_signal(0, 7);
      m_try("R3 waits for both", 7, 1, 0, 7);   // R4: all pipes stalled
      v_try("R4 subcore stall all", 1, 7, 2, 0, 7);
      v_signal(1, 7);
      m_try("R3 both signalled", 7, 1, 1, 0);
      m_try("R3 one each consumed", 7, 1, 0, -1);
      v_signal(1, 7);
      m_try("R3 subcore0 drained", 7, 0, 0, -1);
   endtask

   task automatic t_directed_route();
      do_reset(1'b1);
      m_signal(2);
      v_try("R5 low id to subcore1", 1, 2, 0, 0, -1);
      v_try("R5 low id to subcore0", 0, 2, 0, 1, 0);
      m_signal(16 + 9);
      v_try("R5 high id to subcore0", 0, 9, 0, 0, -1);
      v_try("R5 high id to subcore1", 1, 9, 0, 1, 0);
   endtask

   task automatic t_directed_wait();
      do_reset(1'b1);
      v_signal(1, 4);
      m_try("R6 low id uses subcore0", 4, 1, 0, 2);   // R7: pipe1 only
      m_try("R6 high id uses subcore1", 16 + 4, 1, 1, 0);
      m_try("R6 subcore1 consumed", 16 + 4, 0, 0, 1);
      v_try("R7 subcore pipe2 only", 0, 11, 2, 0, 4);
      check("R7 other subcore idle", int'(v_stall[1]), 0);
   endtask

   task automatic t_saturate();
      do_reset(1'b0);
      for (int i = 0; i < 17; i++) m_signal(1);
      check("R9 sat flag set", int'(sat_flag), 1);
      for (int i = 0; i < 15; i++) v_try("R9 holds fifteen", 0, 1, 0, 1, -1);
      v_try("R9 no sixteenth", 0, 1, 0, 0, -1);
      repeat (2) step();
      check("R9 flag sticky", int'(sat_flag), 1);
   endtask

   task automatic t_simultaneous();
      do_reset(1'b0);
      m_signal(6);
      m_sig_valid = 1; m_sig_id = 5'd6;
      v_wait_valid[0] = 1; v_wait_id[0] = 4'd6;
      #1;
      check("R11 wait completes", int'(v_wait_done[0]), 1);
      step();
      m_sig_valid = 0; v_wait_valid = '0;
      v_try("R11 count unchanged", 0, 6, 0, 1, -1);
      v_try("R11 count unchanged", 0, 6, 0, 0, -1);
      v_try("R11 other subcore two", 1, 6, 0, 1, -1);
      v_try("R11 other subcore two", 1, 6, 0, 1, -1);
   endtask

   task automatic t_mode_frozen();
      do_reset(1'b0);
      cfg_p2p = 1;
      step();
      m_signal(16 + 3);
      v_try("R10 still shared", 0, 3, 0, 1, -1);
      v_try("R10 pending stalls all", 0, 8, 1, 0, 7);
   endtask

   initial begin
      rst_n = 0; cfg_p2p = 0;
      idle_inputs();
      t_reset();
      t_shared_signal();
      t_shared_reduce();
      t_directed_route();
      t_directed_wait();
      t_saturate();
      t_simultaneous();
      t_mode_frozen();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule